// File: doc/BRIEF.md
# Enable Detect and Power Sequencer

This block brings a driver up and down from one digital input that serves two purposes: it enables the device and it carries the PWM brightness signal. A high level held long enough on that input turns the supply regulators on. The block then waits until both supply monitors report good. It then raises the converter's current limit in eight equal steps. When the ramp is complete, the converter and a dimming output follow the input level directly.

A low-time watchdog turns the device off after the input has stayed low for a long time. The watchdog restarts every time the input goes high, so normal dimming never trips it. The soft-start ramp jumps straight to full scale if feedback reaches 75% of nominal first. A supply monitor that drops while the device is powered inhibits switching, asserts the fault flag and sends the sequencer back to wait for good supplies.

All times are counted in system-clock cycles and set by parameters. The input is assumed to be synchronous to the clock.

Top module: `pwr_sequencer`

## Requirements
- R1: The regulator enable `regEn` rises right after the clock edge at which `pwmIn` has been sampled high for `QUAL_CYC` consecutive edges. A high pulse that lasts fewer edges leaves `regEn` low.
- R2: After reset, and whenever the device is off, `regEn`, `convRun`, `dimOut` and `faultOut` are low and `ilimStep` is 0.
- R3: While powered, if `pwmIn` is sampled low on `SHDN_CYC` consecutive edges, `regEn` falls after the last of them and the device returns to off. Any high sample restarts the count.
- R4: Soft-start begins only once `ldoOk` and `drvOk` are both high. Until then `ilimStep` is 0 and `convRun` is low.
- R5: Soft-start starts at `ilimStep` = 0 and adds one every `SS_CYC/8` edges. After 8 steps it enters run, where `ilimStep` reads 7 (full scale).
- R6: In run, `convRun` and `dimOut` are combinational in-phase copies of `pwmIn`. `dimOut` is low at all times before run. `convRun` is high throughout soft-start.
- R7: `faultOut` is high whenever the device is powered and either `ldoOk` or `drvOk` is low. If this happens during soft-start or run, the next edge stops the converter (`convRun`=0, `dimOut`=0, `ilimStep`=0). Once both flags are good again, soft-start restarts from step 0.
- R8: During soft-start, a high `fbAt75` moves the sequencer to run on the next edge, with `ilimStep` at 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwmIn | input | 1 | Combined enable and PWM dimming input |
| ldoOk | input | 1 | Logic supply undervoltage monitor good |
| drvOk | input | 1 | Gate-driver supply undervoltage monitor good |
| fbAt75 | input | 1 | Feedback has reached 75% of nominal |
| regEn | output | 1 | Enable for both linear regulators |
| ilimStep | output | 3 | Soft-start current-limit step code, 7 = full scale |
| convRun | output | 1 | Converter switching allowed |
| dimOut | output | 1 | Buffered dimming switch drive |
| faultOut | output | 1 | Supply fault indication |

## Verification
The hardest situation to reach from the ports is a long dimming sequence that comes close to the shutdown limit without reaching it. The stimulus holds the input low for most of the watchdog window, pulses it high for one cycle, and then holds it low again for most of the window. The device must stay powered, which shows that the count restarts. A separate scenario holds the input low for one edge less than the limit and then exactly to the limit. A supply drop is injected in the middle of run to show that soft-start restarts from step 0.

// File: rtl/seq_pkg.sv
package seq_pkg;
  parameter int unsigned SS_STEPS = 8;
  localparam int unsigned STEP_W = $clog2(SS_STEPS);

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_QUAL = 3'd1,
    ST_WAIT = 3'd2,
    ST_SOFT = 3'd3,
    ST_RUN  = 3'd4
  } seqState_t;

  typedef struct packed {
    logic qualClr;
    logic qualInc;
    logic lowClr;
    logic lowInc;
    logic ssClr;
    logic ssRun;
  } seqStrobes_t;
endpackage

// File: rtl/seq_dp.sv
module seq_dp
  import seq_pkg::*;
#(
  parameter int unsigned QUAL_CYC = 8,
  parameter int unsigned SHDN_CYC = 64,
  parameter int unsigned SS_CYC   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobes_t       stb,
  output logic              qualDone,
  output logic              lowExpired,
  output logic              ssDone,
  output logic [STEP_W-1:0] stepCode
);
  localparam int unsigned STEP_CYC = SS_CYC / SS_STEPS;
  localparam int unsigned QW = $clog2(QUAL_CYC + 1);
  localparam int unsigned LW = $clog2(SHDN_CYC + 1);
  localparam int unsigned SW = $clog2(STEP_CYC + 1);
  localparam logic [QW-1:0] QUAL_LAST = QW'(QUAL_CYC - 2);
  localparam logic [LW-1:0] LOW_LAST  = LW'(SHDN_CYC - 1);
  localparam logic [SW-1:0] STEP_LAST = SW'(STEP_CYC - 1);
  localparam logic [STEP_W-1:0] CODE_MAX = STEP_W'(SS_STEPS - 1);

  logic [QW-1:0] qualCnt;
  logic [LW-1:0] lowCnt;
  logic [SW-1:0] ssCnt;
  logic          stepTick;

  assign qualDone   = (qualCnt == QUAL_LAST);
  assign lowExpired = (lowCnt == LOW_LAST);
  assign stepTick   = (ssCnt == STEP_LAST);
  assign ssDone     = stepTick && (stepCode == CODE_MAX);

  // enable pulse qualification counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           qualCnt <= '0;
    else if (stb.qualClr) qualCnt <= '0;
    else if (stb.qualInc && !qualDone) qualCnt <= qualCnt + 1'b1;
  end

  // low-time shutdown watchdog
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lowCnt <= '0;
    else if (stb.lowClr) lowCnt <= '0;
    else if (stb.lowInc && !lowExpired) lowCnt <= lowCnt + 1'b1;
  end

  // soft-start step timer and code
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ssCnt    <= '0;
      stepCode <= '0;
    end else if (stb.ssClr) begin
      ssCnt    <= '0;
      stepCode <= '0;
    end else if (stb.ssRun) begin
      if (stepTick) begin
        ssCnt <= '0;
        if (stepCode != CODE_MAX) stepCode <= stepCode + 1'b1;
      end else begin
        ssCnt <= ssCnt + 1'b1;
      end
    end
  end

  p_low_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lowCnt <= LOW_LAST);

  p_step_rises_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.ssRun && $past(stb.ssRun)) |-> (stepCode >= $past(stepCode)));

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stb.ssClr) |-> (stepCode == '0));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwmIn,
  input  logic              ldoOk,
  input  logic              drvOk,
  input  logic              fbAt75,
  input  logic              qualDone,
  input  logic              lowExpired,
  input  logic              ssDone,
  input  logic [STEP_W-1:0] stepCode,
  output seqStrobes_t       stb,
  output logic              regEn,
  output logic [STEP_W-1:0] ilimStep,
  output logic              convRun,
  output logic              dimOut,
  output logic              faultOut
);
  localparam logic [STEP_W-1:0] CODE_MAX = STEP_W'(SS_STEPS - 1);

  seqState_t state, stateNext;
  logic powered, bothOk;

  assign powered = (state == ST_WAIT) || (state == ST_SOFT) || (state == ST_RUN);
  assign bothOk  = ldoOk && drvOk;

  always_comb begin
    stateNext = state;
    stb       = '0;
    stb.ssClr = (state != ST_SOFT);
    case (state)
      ST_OFF: begin
        stb.qualClr = 1'b1;
        if (pwmIn) stateNext = ST_QUAL;
      end
      ST_QUAL: begin
        stb.qualInc = 1'b1;
        if (!pwmIn)        stateNext = ST_OFF;
        else if (qualDone) stateNext = ST_WAIT;
      end
      ST_WAIT: if (bothOk) stateNext = ST_SOFT;
      ST_SOFT: begin
        stb.ssRun = 1'b1;
        if (fbAt75 || ssDone) stateNext = ST_RUN;
      end
      default: ;
    endcase
    if (powered) begin
      stb.lowClr = pwmIn;
      stb.lowInc = !pwmIn;
      if (!bothOk && state != ST_WAIT) stateNext = ST_WAIT;
      if (!pwmIn && lowExpired)        stateNext = ST_OFF;
    end else begin
      stb.lowClr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= stateNext;
  end

  always_comb begin
    regEn    = powered;
    faultOut = powered && !bothOk;
    convRun  = (state == ST_SOFT) || ((state == ST_RUN) && pwmIn);
    dimOut   = (state == ST_RUN) && pwmIn;
    case (state)
      ST_SOFT: ilimStep = stepCode;
      ST_RUN:  ilimStep = CODE_MAX;
      default: ilimStep = '0;
    endcase
  end

  p_enable_after_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(regEn) |-> $past(pwmIn));

  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !regEn |-> (!convRun && !dimOut && !faultOut && ilimStep == '0));

  p_shutdown_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(regEn) |-> !$past(pwmIn));

  p_dim_in_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dimOut |-> (pwmIn && ilimStep == CODE_MAX));

  p_fault_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(faultOut && !$past(faultOut)) && $past(regEn) && regEn |-> !dimOut);

  p_early_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state == ST_SOFT && fbAt75 && bothOk && pwmIn)) |-> (ilimStep == CODE_MAX));
endmodule

// File: rtl/pwr_sequencer.sv
module pwr_sequencer
  import seq_pkg::*;
#(
  parameter int unsigned QUAL_CYC = 20000,
  parameter int unsigned SHDN_CYC = 2000000,
  parameter int unsigned SS_CYC   = 600000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwmIn,
  input  logic              ldoOk,
  input  logic              drvOk,
  input  logic              fbAt75,
  output logic              regEn,
  output logic [STEP_W-1:0] ilimStep,
  output logic              convRun,
  output logic              dimOut,
  output logic              faultOut
);
  seqStrobes_t       stb;
  logic              qualDone, lowExpired, ssDone;
  logic [STEP_W-1:0] stepCode;

  seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .pwmIn(pwmIn), .ldoOk(ldoOk), .drvOk(drvOk),
    .fbAt75(fbAt75), .qualDone(qualDone), .lowExpired(lowExpired),
    .ssDone(ssDone), .stepCode(stepCode), .stb(stb), .regEn(regEn),
    .ilimStep(ilimStep), .convRun(convRun), .dimOut(dimOut), .faultOut(faultOut)
  );

  seq_dp #(.QUAL_CYC(QUAL_CYC), .SHDN_CYC(SHDN_CYC), .SS_CYC(SS_CYC)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .qualDone(qualDone),
    .lowExpired(lowExpired), .ssDone(ssDone), .stepCode(stepCode)
  );
endmodule

// File: tb/tb_pwr_sequencer.sv
`timescale 1ns/1ps
module tb_pwr_sequencer;
  localparam int QUAL = 8;
  localparam int SHDN = 64;
  localparam int SS   = 64;
  localparam int STEP = SS / 8;

  logic clk = 0, rst_n = 0, pwmIn = 0, ldoOk = 0, drvOk = 0, fbAt75 = 0;
  logic regEn, convRun, dimOut, faultOut;
  logic [2:0] ilimStep;
  int nChk = 0, nBad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pwr_sequencer #(.QUAL_CYC(QUAL), .SHDN_CYC(SHDN), .SS_CYC(SS)) dut (
    .clk(clk), .rst_n(rst_n), .pwmIn(pwmIn), .ldoOk(ldoOk), .drvOk(drvOk),
    .fbAt75(fbAt75), .regEn(regEn), .ilimStep(ilimStep), .convRun(convRun),
    .dimOut(dimOut), .faultOut(faultOut)
  );

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    step(2);
    chk("R2 regEn at reset", regEn, 0);
    chk("R2 ilimStep at reset", ilimStep, 0);
    chk("R2 convRun at reset", convRun, 0);
    chk("R2 dimOut at reset", dimOut, 0);
    chk("R2 faultOut at reset", faultOut, 0);
  endtask

  task automatic t_short_pulse;
    pwmIn = 1; step(QUAL - 1);
    pwmIn = 0; step(3);
    chk("R1 short pulse ignored", regEn, 0);
  endtask

  task automatic t_qualify;
    pwmIn = 1; step(QUAL - 1);
    chk("R1 not yet enabled", regEn, 0);
    step(1);
    chk("R1 enabled after qualification", regEn, 1);
  endtask

  task automatic t_wait_supplies;
    step(5);
    chk("R4 no ramp before supplies", ilimStep, 0);
    chk("R4 converter idle before supplies", convRun, 0);
    chk("R7 fault while supplies low", faultOut, 1);
    chk("R6 dimOut low before run", dimOut, 0);
    ldoOk = 1; drvOk = 1; step(1);
    chk("R4 soft-start entered", convRun, 1);
    chk("R5 first step code", ilimStep, 0);
    chk("R7 fault clears", faultOut, 0);
  endtask

  task automatic t_ramp;
    for (int k = 1; k < 8; k++) begin
      step(STEP);
      chk("R5 ramp step code", ilimStep, k);
      chk("R6 dimOut low during ramp", dimOut, 0);
    end
    step(STEP);
    chk("R5 full scale in run", ilimStep, 7);
    chk("R6 dimOut follows high", dimOut, 1);
  endtask

  task automatic t_dimming;
    pwmIn = 0; #1;
    chk("R6 convRun follows low", convRun, 0);
    chk("R6 dimOut follows low", dimOut, 0);
    step(SHDN - 20);
    chk("R3 still on before limit", regEn, 1);
    pwmIn = 1; #1;
    chk("R6 dimOut follows high again", dimOut, 1);
    chk("R6 convRun follows high again", convRun, 1);
    step(1);
    pwmIn = 0; step(SHDN - 2);
    pwmIn = 1; step(1);
    pwmIn = 0; step(SHDN - 2);
    chk("R3 watchdog restarted by pulse", regEn, 1);
    pwmIn = 1; step(2);
  endtask

  task automatic t_shutdown;
    pwmIn = 0; step(SHDN - 1);
    chk("R3 on one edge before limit", regEn, 1);
    step(1);
    chk("R3 off at limit", regEn, 0);
    chk("R2 ilimStep zero when off", ilimStep, 0);
    chk("R2 convRun low when off", convRun, 0);
  endtask

  task automatic t_early_finish;
    pwmIn = 1; step(QUAL);
    chk("R1 re-enabled", regEn, 1);
    step(1);
    chk("R4 soft-start with good supplies", convRun, 1);
    step(2 * STEP);
    chk("R5 two steps done", ilimStep, 2);
    fbAt75 = 1; step(1);
    chk("R8 early finish full scale", ilimStep, 7);
    chk("R8 run after early finish", dimOut, 1);
    fbAt75 = 0;
  endtask

  task automatic t_supply_drop;
    drvOk = 0; #1;
    chk("R7 fault on supply drop", faultOut, 1);
    step(1);
    chk("R7 converter stopped", convRun, 0);
    chk("R7 dimOut stopped", dimOut, 0);
    chk("R7 ramp code cleared", ilimStep, 0);
    chk("R7 regulators stay on", regEn, 1);
    drvOk = 1; step(1);
    chk("R7 soft-start restarts", convRun, 1);
    chk("R7 restart at step zero", ilimStep, 0);
    step(STEP);
    chk("R7 restart ramps", ilimStep, 1);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    t_reset();
    t_short_pulse();
    t_qualify();
    t_wait_supplies();
    t_ramp();
    t_dimming();
    t_shutdown();
    t_early_finish();
    t_supply_drop();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end
endmodule